// File: doc/BRIEF.md
# Slice-Serial Keccak-f[400] Permutation Engine

This block computes the Keccak-f[400] permutation on a 400-bit state held as 25 lanes of 16 bits. Each lane sits in its own shift register, and one combinational slice function sees one 25-bit slice (bit z of every lane) per clock. That function applies pi, chi and iota of one round and then theta of the next round. Because of this the permutation runs as 21 passes over the state instead of 40. Rho needs no slice logic. Each lane register applies its own fixed rotation on the last shift of a pass. Theta needs the column parities of the slice below, so a 5-bit parity register carries them from one cycle to the next. A one-cycle pre-pass at the start of every pass loads that register with the parities of the top slice, which covers the wrap at z = 0.

Two independent state banks share the one slice datapath, and `bank_sel` picks between them. A user loads a bank in parallel while it is idle. A user starts a permutation with a one-cycle `start` pulse, waits for the one-cycle `done` flag and reads the bank back in parallel through `state_out`. While one bank is permuting, the other bank can still be loaded and read.

Top module: `keccak400_slice_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every bank holds all zeros, as seen on `state_out` for each value of `bank_sel`.
- R2: With `busy` low, a cycle with `load_en` high writes `load_state` into the bank named by `bank_sel`. `state_out` always shows the bank named by `bank_sel`, and an idle bank with no load keeps its contents.
- R3: A run replaces the started bank with Keccak-f[400] of its contents, using the following conventions.
  - Lane (x,y) occupies bits 16(x+5y)+15 down to 16(x+5y), and bit z of a lane is slice z.
  - There are 20 rounds, numbered 0 to 19. Each round applies theta, rho, pi, chi and iota in that order.
  - The rho offsets are the standard triangular-number offsets taken modulo 16.
  - The iota constant of round i is the low 16 bits of the standard 64-bit constant. Its only nonzero positions are bits 0, 1, 3, 7 and 15.
- R4: `start` is accepted when `busy` is low. `busy` rises on that edge and stays high for exactly 357 cycles. `done` is set on the 357th rising edge after the accepting edge.
- R5: A `start` pulse while `busy` is high is ignored. It neither restarts nor lengthens the run nor queues a second one, and `busy` stays low after `done`.
- R6: A run leaves every bank other than the started one unchanged, apart from loads into it. A load into a non-running bank during a run takes effect normally.
- R7: A load aimed at the running bank while `busy` is high is ignored and does not disturb the result.
- R8: `done` is high for exactly one cycle per run, and `busy` is low in that cycle.
- R9: The bank that is permuted is the one selected when `start` was accepted. Changing `bank_sel` during the run does not move the work to another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Bank chosen for load, start and read-out |
| load_en | input | 1 | Parallel write of `load_state` into the selected bank |
| load_state | input | 400 | State value to load |
| start | input | 1 | Pulse that starts a permutation of the selected bank |
| busy | output | 1 | High while a permutation is running |
| done | output | 1 | One-cycle flag after the final pass |
| state_out | output | 400 | Contents of the selected bank |

## Verification
The bench compares every run with a full-width software permutation. The all-ones pattern and single bits at bit 0 and bit 399 would expose an error in the z = 0 parity wrap, a lane rotation off by one, or an iota bit placed at the wrong slice, since any of these makes the result differ from the model. A chained second run on a result, where the input carries all the structure of a previous run, would show a wrong parity seed or a skipped final-pass condition. A directed run raises `start` twice in mid-run, loads the idle bank, aims a load at the running bank and flips `bank_sel` mid-run. A design that restarted, queued a start, followed `bank_sel` or accepted a load into the running bank would then show a wrong latency, an extra busy period or a corrupted result.

// File: rtl/ks_pkg.sv
package ks_pkg;

   // phases of the slice sequencer
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_RUN  = 2'd2
   } ks_phase_e;

   localparam int KS_PLANE = 5;
   localparam int KS_LANES = KS_PLANE * KS_PLANE;

   // one output bit of the round-constant LFSR (x^8+x^6+x^5+x^4+1)
   function automatic logic rc_lfsr(input int t);
      logic [7:0] r;
      logic       msb;
      int         n;
      n = t % 255;
      r = 8'h01;
      for (int i = 1; i <= n; i++) begin
         msb = r[7];
         r   = {r[6:0], 1'b0};
         if (msb) r = r ^ 8'h71;
      end
      return r[0];
   endfunction

   // 64-bit iota constant of a round; narrower lanes keep the low bits
   function automatic logic [63:0] rc_word(input int rnd);
      logic [63:0] w;
      w = '0;
      for (int j = 0; j < 7; j++) w[(1 << j) - 1] = rc_lfsr(j + 7 * rnd);
      return w;
   endfunction

   // rho rotation of lane index idx = x+5y, reduced to the lane width
   function automatic int rho_off(input int idx, input int lane_w);
      int offs [KS_LANES];
      int x;
      int y;
      int tx;
      x = 1;
      y = 0;
      offs[0] = 0;
      for (int t = 0; t < KS_LANES - 1; t++) begin
         offs[x + KS_PLANE * y] = (((t + 1) * (t + 2)) / 2) % lane_w;
         tx = y;
         y  = (2 * x + 3 * y) % KS_PLANE;
         x  = tx;
      end
      return offs[idx];
   endfunction

endpackage

// File: rtl/ks_lane.sv
module ks_lane #(
   parameter int LANE_W = 16,
   parameter int ROT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [LANE_W-1:0] ld_val,
   input  logic              sh_en,
   input  logic              rot_en,
   input  logic              in_bit,
   output logic [LANE_W-1:0] q
);

   logic [LANE_W-1:0] q_r;
   logic [LANE_W-1:0] shifted;
   logic [LANE_W-1:0] rotated;

   initial begin
      assert (ROT >= 0 && ROT < LANE_W)
         else $fatal(1, "ks_lane: rotation out of range");
   end

   // new slice enters at the top, slice 0 leaves at the bottom
   assign shifted = {in_bit, q_r[LANE_W-1:1]};

   generate
      if (ROT == 0) begin : g_norot
         assign rotated = shifted;
      end else begin : g_rot
         assign rotated = {shifted[LANE_W-1-ROT:0], shifted[LANE_W-1:LANE_W-ROT]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (ld_en) begin
         q_r <= ld_val;
      end else if (sh_en) begin
         q_r <= rot_en ? rotated : shifted;
      end
   end

   assign q = q_r;

endmodule

// File: rtl/ks_lane_bank.sv
module ks_lane_bank #(
   parameter int LANE_W  = 16,
   localparam int NLANE  = ks_pkg::KS_LANES,
   localparam int STATE_W = NLANE * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [STATE_W-1:0] ld_val,
   input  logic               sh_en,
   input  logic               rot_en,
   input  logic [NLANE-1:0]   new_slice,
   output logic [STATE_W-1:0] state_q,
   output logic [NLANE-1:0]   slice_lo,
   output logic [NLANE-1:0]   slice_hi
);

   genvar i;
   generate
      for (i = 0; i < NLANE; i++) begin : g_lane
         logic [LANE_W-1:0] lane_q;
         ks_lane #(
            .LANE_W (LANE_W),
            .ROT    (ks_pkg::rho_off(i, LANE_W))
         ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_en  (ld_en),
            .ld_val (ld_val[i*LANE_W +: LANE_W]),
            .sh_en  (sh_en),
            .rot_en (rot_en),
            .in_bit (new_slice[i]),
            .q      (lane_q)
         );
         assign state_q[i*LANE_W +: LANE_W] = lane_q;
         assign slice_lo[i] = lane_q[0];
         assign slice_hi[i] = lane_q[LANE_W-1];
      end
   endgenerate

endmodule

// File: rtl/ks_slice_fn.sv
module ks_slice_fn #(
   localparam int P     = ks_pkg::KS_PLANE,
   localparam int NLANE = ks_pkg::KS_LANES
) (
   input  logic             do_pci,
   input  logic             do_theta,
   input  logic             rc_bit,
   input  logic [NLANE-1:0] slice_in,
   input  logic [P-1:0]     prev_par,
   output logic [NLANE-1:0] slice_out,
   output logic [P-1:0]     cur_par
);

   logic [NLANE-1:0] pi_s;
   logic [NLANE-1:0] chi_s;
   logic [NLANE-1:0] b_s;
   logic [P-1:0]     dcol;

   genvar x, y;
   generate
      for (x = 0; x < P; x++) begin : g_x
         for (y = 0; y < P; y++) begin : g_y
            localparam int SRC = x + P * y;
            localparam int DST = y + P * ((2 * x + 3 * y) % P);
            localparam int N1  = ((x + 1) % P) + P * y;
            localparam int N2  = ((x + 2) % P) + P * y;
            assign pi_s[DST]  = slice_in[SRC];
            assign chi_s[SRC] = pi_s[SRC] ^ (~pi_s[N1] & pi_s[N2]);
            assign slice_out[SRC] = b_s[SRC] ^ (do_theta & dcol[x]);
         end
         assign cur_par[x] = b_s[x] ^ b_s[x + P] ^ b_s[x + 2*P] ^ b_s[x + 3*P] ^ b_s[x + 4*P];
      end
      for (x = 0; x < P; x++) begin : g_d
         assign dcol[x] = cur_par[(x + P - 1) % P] ^ prev_par[(x + 1) % P];
      end
   endgenerate

   always_comb begin
      b_s = slice_in;
      if (do_pci) begin
         b_s    = chi_s;
         b_s[0] = chi_s[0] ^ rc_bit;
      end
   end

endmodule

// File: rtl/ks_round_seq.sv
module ks_round_seq #(
   parameter int LANE_W     = 16,
   parameter int NUM_ROUNDS = 20,
   localparam int Z_W = $clog2(LANE_W),
   localparam int P_W = $clog2(NUM_ROUNDS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done,
   output logic pre_ph,
   output logic sh_en,
   output logic rot_en,
   output logic do_pci,
   output logic do_theta,
   output logic rc_bit
);

   import ks_pkg::*;

   localparam logic [Z_W-1:0] Z_LAST = Z_W'(LANE_W - 1);
   localparam logic [P_W-1:0] P_LAST = P_W'(NUM_ROUNDS);
   localparam int RC_DEPTH = 1 << P_W;

   ks_phase_e         st_q;
   logic [Z_W-1:0]    z_q;
   logic [P_W-1:0]    pass_q;
   logic              done_q;
   logic [P_W-1:0]    rnd_idx;
   logic [Z_W-1:0]    bit_idx;
   logic [LANE_W-1:0] rc_tab [RC_DEPTH];

   genvar g;
   generate
      for (g = 0; g < RC_DEPTH; g++) begin : g_rc
         if (g < NUM_ROUNDS) begin : g_used
            localparam logic [63:0] RCW = rc_word(g);
            assign rc_tab[g] = RCW[LANE_W-1:0];
         end else begin : g_pad
            assign rc_tab[g] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         z_q    <= '0;
         pass_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            PH_IDLE: begin
               if (go) begin
                  pass_q <= '0;
                  st_q   <= PH_PRE;
               end
            end
            PH_PRE: begin
               z_q  <= '0;
               st_q <= PH_RUN;
            end
            PH_RUN: begin
               z_q <= z_q + 1'b1;
               if (z_q == Z_LAST) begin
                  if (pass_q == P_LAST) begin
                     st_q   <= PH_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     pass_q <= pass_q + 1'b1;
                     st_q   <= PH_PRE;
                  end
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != PH_IDLE);
   assign done     = done_q;
   assign pre_ph   = (st_q == PH_PRE);
   assign sh_en    = (st_q == PH_RUN);
   assign do_pci   = (pass_q != '0);
   assign do_theta = (pass_q != P_LAST);
   assign rot_en   = sh_en && (z_q == Z_LAST) && do_theta;
   assign rnd_idx  = do_pci ? (pass_q - 1'b1) : '0;
   assign bit_idx  = pre_ph ? Z_LAST : z_q;
   assign rc_bit   = rc_tab[rnd_idx][bit_idx];

endmodule

// File: rtl/keccak400_slice_engine.sv
module keccak400_slice_engine #(
   parameter int NUM_BANKS  = 2,
   parameter int LANE_W     = 16,
   parameter int NUM_ROUNDS = 20,
   localparam int STATE_W = ks_pkg::KS_LANES * LANE_W,
   localparam int SEL_W   = $clog2(NUM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   bank_sel,
   input  logic               load_en,
   input  logic [STATE_W-1:0] load_state,
   input  logic               start,
   output logic               busy,
   output logic               done,
   output logic [STATE_W-1:0] state_out
);

   localparam int NLANE = ks_pkg::KS_LANES;
   localparam int P     = ks_pkg::KS_PLANE;

   initial begin
      assert (NUM_BANKS >= 2) else $fatal(1, "need at least two banks");
      assert (LANE_W >= 2 && LANE_W <= 64 && (LANE_W & (LANE_W - 1)) == 0)
         else $fatal(1, "lane width must be a power of two up to 64");
      assert (NUM_ROUNDS >= 1 && NUM_ROUNDS <= 24)
         else $fatal(1, "round count out of range");
   end

   logic               sel_ok;
   logic               accept;
   logic [SEL_W-1:0]   run_bank;
   logic               pre_ph, sh_en, rot_en, do_pci, do_theta, rc_bit;
   logic [NLANE-1:0]   slice_in, slice_new;
   logic [P-1:0]       par_q, par_cur;
   logic [STATE_W-1:0] bank_q  [NUM_BANKS];
   logic [NLANE-1:0]   lo_b    [NUM_BANKS];
   logic [NLANE-1:0]   hi_b    [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_ld, bank_sh;

   generate
      if (NUM_BANKS == (1 << SEL_W)) begin : g_full
         assign sel_ok = 1'b1;
      end else begin : g_part
         assign sel_ok = (int'(bank_sel) < NUM_BANKS);
      end
   endgenerate

   assign accept = start && !busy && sel_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_bank <= '0;
      end else if (accept) begin
         run_bank <= bank_sel;
      end
   end

   ks_round_seq #(
      .LANE_W     (LANE_W),
      .NUM_ROUNDS (NUM_ROUNDS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (accept),
      .busy     (busy),
      .done     (done),
      .pre_ph   (pre_ph),
      .sh_en    (sh_en),
      .rot_en   (rot_en),
      .do_pci   (do_pci),
      .do_theta (do_theta),
      .rc_bit   (rc_bit)
   );

   // pre-pass reads the top slice to seed the parity register
   assign slice_in = pre_ph ? hi_b[run_bank] : lo_b[run_bank];

   ks_slice_fn u_slice (
      .do_pci    (do_pci),
      .do_theta  (do_theta),
      .rc_bit    (rc_bit),
      .slice_in  (slice_in),
      .prev_par  (par_q),
      .slice_out (slice_new),
      .cur_par   (par_cur)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_q <= '0;
      end else if (pre_ph || sh_en) begin
         par_q <= par_cur;
      end
   end

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_ld[b] = load_en && sel_ok && (bank_sel == SEL_W'(b))
                             && !(busy && (run_bank == SEL_W'(b)));
         assign bank_sh[b] = sh_en && (run_bank == SEL_W'(b));
         ks_lane_bank #(
            .LANE_W (LANE_W)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_en     (bank_ld[b]),
            .ld_val    (load_state),
            .sh_en     (bank_sh[b]),
            .rot_en    (rot_en),
            .new_slice (slice_new),
            .state_q   (bank_q[b]),
            .slice_lo  (lo_b[b]),
            .slice_hi  (hi_b[b])
         );
      end
   endgenerate

   assign state_out = sel_ok ? bank_q[bank_sel] : '0;

endmodule

// File: rtl/ks_engine_checker.sv
module ks_engine_checker #(
   parameter int SEL_W   = 1,
   parameter int STATE_W = 400,
   parameter int TOTAL   = 357
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               load_en,
   input logic [SEL_W-1:0]   bank_sel,
   input logic [STATE_W-1:0] state_out,
   input logic [SEL_W-1:0]   run_bank
);

   int busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) busy_cnt <= 0;
      else                 busy_cnt <= busy_cnt + 1;
   end

   // R8: done lasts a single cycle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: the engine is idle while done is shown
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4: the busy period before done has the fixed length
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cnt == TOTAL));

   // R4: a run only begins after a start request
   p_busy_from_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R9: the bank being permuted does not change mid-run
   p_run_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(run_bank));

   // R2: an idle bank with no load keeps what it shows
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_en && !start) |=> ((bank_sel != $past(bank_sel)) || $stable(state_out)));

endmodule

bind keccak400_slice_engine ks_engine_checker #(
   .SEL_W   (SEL_W),
   .STATE_W (STATE_W),
   .TOTAL   ((NUM_ROUNDS + 1) * (LANE_W + 1))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .load_en   (load_en),
   .bank_sel  (bank_sel),
   .state_out (state_out),
   .run_bank  (run_bank)
);

// File: tb/keccak400_slice_engine_tb_top.sv
module keccak400_slice_engine_tb_top;

   localparam int SW      = 400;
   localparam int RUN_LAT = 357;   // R4: 21 passes of 17 cycles

   localparam logic [15:0] RC_T [20] = '{
      16'h0001, 16'h8082, 16'h808A, 16'h8000, 16'h808B,
      16'h0001, 16'h8081, 16'h8009, 16'h008A, 16'h0088,
      16'h8009, 16'h000A, 16'h808B, 16'h008B, 16'h8089,
      16'h8003, 16'h8002, 16'h0080, 16'h800A, 16'h000A };

   localparam int RHO_T [25] = '{
      0, 1, 14, 12, 11,
      4, 12, 6, 7, 4,
      3, 10, 11, 9, 7,
      9, 13, 15, 5, 8,
      2, 2, 13, 8, 14 };

   localparam logic [SW-1:0] VEC [6] = '{
      {SW{1'b0}},
      {SW{1'b1}},
      {{(SW-1){1'b0}}, 1'b1},
      {1'b1, {(SW-1){1'b0}}},
      {25{16'hA5C3}},
      {20{20'h9E37B}} };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [0:0]    bank_sel;
   logic          load_en;
   logic [SW-1:0] load_state;
   logic          start;
   logic          busy;
   logic          done;
   logic [SW-1:0] state_out;

   int n_chk  = 0;
   int n_fail = 0;
   logic [SW-1:0] exp_bank [2];

   always #4 clk = ~clk;

   keccak400_slice_engine dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_sel   (bank_sel),
      .load_en    (load_en),
      .load_state (load_state),
      .start      (start),
      .busy       (busy),
      .done       (done),
      .state_out  (state_out)
   );

   function automatic logic [15:0] rotl16(input logic [15:0] v, input int n);
      if (n == 0) return v;
      return (v << n) | (v >> (16 - n));
   endfunction

   function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] s_in);
      logic [15:0] a [25];
      logic [15:0] b [25];
      logic [15:0] c [5];
      logic [15:0] d [5];
      logic [SW-1:0] s_out;
      for (int i = 0; i < 25; i++) a[i] = s_in[16*i +: 16];
      for (int r = 0; r < 20; r++) begin
         for (int x = 0; x < 5; x++) c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
         for (int x = 0; x < 5; x++) d[x] = c[(x+4)%5] ^ rotl16(c[(x+1)%5], 1);
         for (int i = 0; i < 25; i++) a[i] = a[i] ^ d[i%5];
         for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++)
               b[y + 5*((2*x + 3*y) % 5)] = rotl16(a[x + 5*y], RHO_T[x + 5*y]);
         for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++)
               a[x + 5*y] = b[x + 5*y] ^ (~b[(x+1)%5 + 5*y] & b[(x+2)%5 + 5*y]);
         a[0] = a[0] ^ RC_T[r];
      end
      for (int i = 0; i < 25; i++) s_out[16*i +: 16] = a[i];
      return s_out;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [SW-1:0] act,
                        input logic [SW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load_bank(input int b, input logic [SW-1:0] v);
      bank_sel   = 1'(b);
      load_en    = 1'b1;
      load_state = v;
      tick();
      load_en    = 1'b0;
      exp_bank[b] = v;
   endtask

   // issue start, wait for done; returns cycles counted from the accepting edge
   task automatic run_wait(input int b, output int lat);
      bank_sel = 1'(b);
      start    = 1'b1;
      tick();
      start    = 1'b0;
      lat      = 0;
      while (!done && lat < 2000) begin
         tick();
         lat++;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R4: watchdog expired, actual no completion expected done");
      summary();
      $finish;
   end

   initial begin
      int lat;
      rst_n      = 1'b0;
      bank_sel   = 1'b0;
      load_en    = 1'b0;
      load_state = '0;
      start      = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check(busy == 1'b0, "R1 busy", SW'(busy), '0);
      check(done == 1'b0, "R1 done", SW'(done), '0);
      check(state_out == '0, "R1 bank0", state_out, '0);
      bank_sel = 1'b1;
      tick();
      check(state_out == '0, "R1 bank1", state_out, '0);
      exp_bank[0] = '0;
      exp_bank[1] = '0;

      // vector table: R2, R3, R4, R6, R8
      for (int i = 0; i < 6; i++) begin
         int b;
         logic [SW-1:0] want;
         b = i % 2;
         load_bank(b, VEC[i]);
         check(state_out == VEC[i], "R2 load", state_out, VEC[i]);
         want = ref_perm(VEC[i]);
         run_wait(b, lat);
         check(lat == RUN_LAT, "R4 latency", SW'(lat), SW'(RUN_LAT));
         check(busy == 1'b0, "R8 busy at done", SW'(busy), '0);
         tick();
         check(done == 1'b0, "R8 done width", SW'(done), '0);
         bank_sel = 1'(b);
         tick();
         check(state_out == want, "R3 result", state_out, want);
         exp_bank[b] = want;
         bank_sel = 1'(1 - b);
         tick();
         check(state_out == exp_bank[1-b], "R6 other bank", state_out, exp_bank[1-b]);
      end

      // chained run on a previous result (R3)
      begin
         logic [SW-1:0] want;
         want = ref_perm(exp_bank[1]);
         run_wait(1, lat);
         check(lat == RUN_LAT, "R4 chained latency", SW'(lat), SW'(RUN_LAT));
         bank_sel = 1'b1;
         tick();
         check(state_out == want, "R3 chained", state_out, want);
      end

      // directed: mid-run start, loads, bank_sel changes (R5, R6, R7, R9)
      begin
         logic [SW-1:0] q_val, p_val, p2_val, junk, want;
         q_val  = {25{16'h1357}};
         p_val  = {50{8'h3C}};
         p2_val = {10{40'hF0E1D2C3B4}};
         junk   = {SW{1'b1}};
         load_bank(1, p_val);
         load_bank(0, q_val);
         want = ref_perm(q_val);
         bank_sel = 1'b0;
         start    = 1'b1;
         tick();
         start = 1'b0;
         lat   = 0;
         while (!done && lat < 2000) begin
            case (lat)
               1: begin bank_sel = 1'b1; load_en = 1'b1; load_state = p2_val; end
               2: begin bank_sel = 1'b0; load_state = junk; end
               3: begin load_en = 1'b0; start = 1'b1; bank_sel = 1'b1; end
               4: start = 1'b0;
               100: begin start = 1'b1; bank_sel = 1'b0; end
               101: begin start = 1'b0; bank_sel = 1'b1; end
               default: ;
            endcase
            tick();
            lat++;
         end
         check(lat == RUN_LAT, "R5 latency with mid-run starts", SW'(lat), SW'(RUN_LAT));
         for (int k = 0; k < 5; k++) begin
            tick();
            check(busy == 1'b0, "R5 no queued start", SW'(busy), '0);
         end
         bank_sel = 1'b0;
         tick();
         check(state_out == want, "R7 R9 run bank result", state_out, want);
         bank_sel = 1'b1;
         tick();
         check(state_out == p2_val, "R6 idle-bank load during run", state_out, p2_val);
      end

      summary();
      $finish;
   end

endmodule